// File: doc/BRIEF.md
# Prioritized Cascading Reset Class Generator

This block collects reset requests from across a chip and produces four ranked reset outputs, one per reset class. Class 0 has the highest priority and covers a full power-on/off style reset. Class 3 has the lowest priority. Each class drives its own reset domain. When a class is raised, every class below it is raised with it. A request to a lower class never raises a class above it.

Every request input is treated as asynchronous, so a class output goes active as soon as a request appears, with no clock edge needed. Release is synchronized to the free-running clock and stretched. After all requests to a class have gone, that class stays active for a fixed minimum time. A lower class only begins its own stretch once the class above it has let go, so the classes come out of reset from highest to lowest.

A sticky cause register records which requests caused resets since the last clear, so software can read it back. A synchronous clear strobe empties it. A fresh class-0 event replaces the old record with the causes of that event. Resets of classes 1 to 3 leave earlier entries in place.

Top module: `rst_class_gen`

## Requirements
- R1: `cls_rst_n` is active low. Bit k is the reset for class k, with class 0 the highest priority. While `por_n` is low, all four bits are 0.
- R2: Each source is tied to exactly one class by the `SRC_CLASS` map. Field bits [2i+1:2i] hold the class of source i. By default, sources 0 to 7 go to class 0. These are: power removal, main-supply exception, core-supply exception, deep low-power exit, external reset pin, debug port, system control, and oscillator short-circuit fault. Source 8 goes to class 1, source 9 to class 2, and source 10 to class 3. `por_n` low is a class-0 request.
- R3: When a class is requested, that class and every class below it are driven to 0 at once, before any clock edge.
- R4: A request tied to class k never drives any class j < k to 0.
- R5: Take a class whose own request drops between clock edges while the class above it is idle. That class stays at 0 through the following 17th rising edge and returns to 1 on the 18th (STRETCH+2).
- R6: A lower class is released only STRETCH+2 rising edges after the class above it is released. With the defaults, a class-0 request released at one moment frees classes 0, 1, 2 and 3 on edges 18, 36, 54 and 72.
- R7: A request that comes back while a class is still stretching restarts the full stretch from its new drop.
- R8: A request pulse shorter than one clock period still asserts its class and cascade at once. It also gets the full stretch and is recorded in the cause register.
- R9: `cause_flags` bit 0 marks a power-on (`por_n` low), and bit i+1 marks source i. Right after `por_n` is released, the value is 1.
- R10: A source's flag is set by the first rising edge after the source goes active. The flag stays set across resets of classes 1 to 3 until a clear or a new class-0 event.
- R11: A `cause_clr` high at a rising edge loads the register with only those sources still seen active. Once all sources have been idle for two edges, the result is 0.
- R12: On the first rising edge where any class-0 source is seen active after none was, the register is loaded with only the sources active at that edge. All older entries are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock used to synchronize and time releases |
| por_n | input | 1 | Power-on reset, active low; a class-0 request and the block's own reset |
| src_req | input | NUM_SRC | Asynchronous reset requests, active high, one bit per source |
| cause_clr | input | 1 | Synchronous clear strobe for the cause register |
| cls_rst_n | output | 4 | Active-low class resets, bit k = class k |
| cause_flags | output | NUM_SRC+1 | Sticky causes: bit 0 power-on, bit i+1 source i |

## Verification
A stretch counter that loads or decrements wrongly shows up as a class release that is early or late by whole cycles. Checking the exact release edge of each class against the STRETCH+2 grid exposes such a fault within one release. A broken cascade shows up at the ports straight away, on the same request edge: either a lower class fails to follow a higher one, or a higher class follows a lower one. A cause register that loses entries, keeps stale ones, or ignores the class-0 restart shows a wrong value one edge after the event that should have changed it.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int NUM_CLASS = 4;
  localparam int CLS_IDX_W = $clog2(NUM_CLASS);
  typedef logic [NUM_CLASS-1:0] cls_vec_t;
endpackage

// File: rtl/rcg_src_sync.sv
// Per-source capture: each bit is set asynchronously by its request and
// drains to zero through two clocked stages, so even a runt pulse is seen
// by at least one rising edge.
module rcg_src_sync #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_SRC-1:0] seen
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic hit_n;
    logic m_q;
    logic o_q;
    assign hit_n = ~src_req[i];

    always_ff @(posedge clk or negedge hit_n) begin
      if (!hit_n) begin
        m_q <= 1'b1;
        o_q <= 1'b1;
      end else begin
        m_q <= 1'b0;
        o_q <= m_q;
      end
    end

    assign seen[i] = o_q;
  end
endmodule

// File: rtl/rcg_class_stage.sv
// One reset class: asynchronous assertion, two-flop release synchronizer,
// then a down-counter that holds the output for STRETCH more edges.
module rcg_class_stage #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_n,
  output logic act
);
  localparam int CNT_W = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH);

  logic             arst_n;
  logic             s1_q, s2_q, act_q, act_d;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign arst_n = req_n & por_n;

  always_comb begin
    cnt_en = s2_q | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (cnt_en) begin
      if (s2_q) cnt_d = CNT_LOAD;
      else      cnt_d = cnt_q - 1'b1;
    end
    act_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      cnt_q <= CNT_LOAD;
      act_q <= 1'b1;
    end else begin
      s1_q  <= 1'b0;
      s2_q  <= s1_q;
      if (cnt_en) cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;

  // R5: while the synchronizer still reports a request, the output is held
  a_r5_sync_holds: assert property (@(posedge clk) disable iff (!por_n)
    s2_q |=> act_q);

  // R5: release only at the end of a fully drained stretch
  a_r5_release_drained: assert property (@(posedge clk) disable iff (!por_n)
    $fell(act_q) |-> ($past(cnt_q) == CNT_W'(1) && !$past(s2_q)));
endmodule

// File: rtl/rcg_cause_log.sv
// Sticky cause register: bit 0 power-on, bit i+1 source i.
module rcg_cause_log #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [NUM_SRC-1:0] seen,
  input  logic [NUM_SRC-1:0] c0_mask,
  input  logic               clr,
  output logic [NUM_SRC:0]   flags
);
  localparam int FW = NUM_SRC + 1;

  logic [NUM_SRC-1:0] seen_d_q;
  logic [FW-1:0]      flags_q, flags_d, capt;
  logic               c0_now, c0_was, start0;

  always_comb begin
    capt   = {seen, 1'b0};
    c0_now = |(seen & c0_mask);
    c0_was = |(seen_d_q & c0_mask);
    start0 = c0_now & ~c0_was;
    if (start0 | clr) flags_d = capt;
    else              flags_d = flags_q | capt;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags_q  <= FW'(1);
      seen_d_q <= '1;
    end else begin
      flags_q  <= flags_d;
      seen_d_q <= seen;
    end
  end

  assign flags = flags_q;

  // R10: without clear or class-0 restart no recorded cause is lost
  a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (!clr && !start0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R12: a new class-0 event drops the power-on mark
  a_r12_restart_drops_por: assert property (@(posedge clk) disable iff (!por_n)
    start0 |=> !flags_q[0]);
endmodule

// File: rtl/rst_class_gen.sv
module rst_class_gen
  import rcg_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int STRETCH = 16,
  parameter logic [2*NUM_SRC-1:0] SRC_CLASS = 22'h39_0000
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               cause_clr,
  output logic [NUM_CLASS-1:0] cls_rst_n,
  output logic [NUM_SRC:0]   cause_flags
);
  logic [NUM_CLASS-1:0][NUM_SRC-1:0] cls_mask;
  cls_vec_t           cls_req, cls_act, cls_req_n;
  logic [NUM_SRC-1:0] seen;

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
      assign cls_mask[k][i] = (SRC_CLASS[2*i +: 2] == CLS_IDX_W'(k));
    end

    assign cls_req[k] = |(src_req & cls_mask[k]);

    if (k == 0) begin : g_top
      assign cls_req_n[k] = por_n & ~cls_req[k];
    end else begin : g_chain
      assign cls_req_n[k] = ~cls_req[k] & ~cls_act[k-1];

      // R3: a class never stands active while the class below it is idle
      a_r3_cascade: assert property (@(posedge clk) disable iff (!por_n)
        cls_act[k-1] |-> cls_act[k]);

      // R6: a lower class lets go only after the class above already had
      a_r6_order: assert property (@(posedge clk) disable iff (!por_n)
        $fell(cls_act[k]) |-> (!cls_act[k-1] && $past(!cls_act[k-1])));
    end

    rcg_class_stage #(.STRETCH(STRETCH)) u_stage (
      .clk   (clk),
      .por_n (por_n),
      .req_n (cls_req_n[k]),
      .act   (cls_act[k])
    );
  end

  rcg_src_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk     (clk),
    .src_req (src_req),
    .seen    (seen)
  );

  rcg_cause_log #(.NUM_SRC(NUM_SRC)) u_log (
    .clk     (clk),
    .por_n   (por_n),
    .seen    (seen),
    .c0_mask (cls_mask[0]),
    .clr     (cause_clr),
    .flags   (cause_flags)
  );

  assign cls_rst_n = ~cls_act;
endmodule

// File: tb/tb_rst_class_gen.sv
module tb_rst_class_gen;
  localparam int NS = 11;
  localparam int ST = 16;
  localparam int P  = ST + 2;

  logic          clk = 1'b0;
  logic          por_n;
  logic [NS-1:0] src;
  logic          clr;
  logic [3:0]    rn;
  logic [NS:0]   flg;

  int n_chk = 0;
  int n_bad = 0;
  bit fin   = 1'b0;

  always #5 clk = ~clk;

  rst_class_gen #(.NUM_SRC(NS), .STRETCH(ST)) dut (
    .clk(clk), .por_n(por_n), .src_req(src), .cause_clr(clr),
    .cls_rst_n(rn), .cause_flags(flg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // counts rising edges until each class output returns high
  task automatic rel_edges(output int rel[4], output logic [3:0] lows);
    rel  = '{default: 0};
    lows = ~rn;
    for (int n = 1; n <= 100; n++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (!rn[k]) lows[k] = 1'b1;
        else if (rel[k] == 0) rel[k] = n;
      end
    end
  endtask

  task automatic t_por();
    int r[4]; logic [3:0] lw;
    repeat (3) @(negedge clk);
    chk("R1 R3 all classes held in power-on", 32'(rn), 32'h0);
    chk("R9 power-on mark during reset", 32'(flg), 32'h1);
    por_n = 1'b1;
    rel_edges(r, lw);
    chk("R5 class0 release edge", r[0], P);
    chk("R6 class1 release edge", r[1], 2*P);
    chk("R6 class2 release edge", r[2], 3*P);
    chk("R6 class3 release edge", r[3], 4*P);
    chk("R9 power-on mark after release", 32'(flg), 32'h1);
  endtask

  task automatic t_lower();
    int r[4]; logic [3:0] lw;
    @(negedge clk); src[9] = 1'b1;
    #1 chk("R3 R4 class2 request, async", 32'(rn), 32'h3);
    @(negedge clk);
    chk("R10 flag after one edge", 32'(flg), 32'h401);
    repeat (3) @(negedge clk);
    chk("R4 upper classes stay idle", 32'(rn), 32'h3);
    src[9] = 1'b0;
    rel_edges(r, lw);
    chk("R4 classes seen low", 32'(lw), 32'hC);
    chk("R5 class2 own release", r[2], P);
    chk("R6 class3 follows class2", r[3], 2*P);
    chk("R10 flags survive class2 reset", 32'(flg), 32'h401);
  endtask

  task automatic t_retrig();
    int r[4]; logic [3:0] lw;
    @(negedge clk); src[8] = 1'b1;
    #1 chk("R2 source8 maps to class1", 32'(rn), 32'h1);
    repeat (5) @(negedge clk);
    src[8] = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 still held mid-stretch", 32'(rn), 32'h1);
    src[8] = 1'b1;
    @(negedge clk); src[8] = 1'b0;
    rel_edges(r, lw);
    chk("R7 class1 restarted stretch", r[1], P);
    chk("R6 class2 after restart", r[2], 2*P);
    chk("R6 class3 after restart", r[3], 3*P);
    chk("R4 class0 untouched by class1", 32'(lw), 32'hE);
    chk("R10 flags survive class1 reset", 32'(flg), 32'h601);
  endtask

  task automatic t_clear();
    int r[4]; logic [3:0] lw;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R11 clear with idle sources", 32'(flg), 32'h0);
    src[10] = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R11 active source kept by clear", 32'(flg), 32'h800);
    src[10] = 1'b0;
    rel_edges(r, lw);
    chk("R5 class3 own release", r[3], P);
    chk("R4 only class3 seen low", 32'(lw), 32'h8);
  endtask

  task automatic t_src0();
    int r[4]; logic [3:0] lw;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); src[i] = 1'b1;
      #1 chk($sformatf("R2 source%0d raises class0", i), 32'(rn), 32'h0);
      @(negedge clk); src[i] = 1'b0;
      rel_edges(r, lw);
      chk($sformatf("R12 flags replaced by source%0d", i), 32'(flg), 32'h1 << (i + 1));
      chk("R5 class0 release after source", r[0], P);
    end
  endtask

  task automatic t_pulse();
    int r[4]; logic [3:0] lw;
    @(negedge clk);
    #2 src[3] = 1'b1;
    #1 chk("R8 runt pulse asserts at once", 32'(rn), 32'h0);
    #1 src[3] = 1'b0;
    rel_edges(r, lw);
    chk("R8 runt pulse full stretch", r[0], P);
    chk("R8 R12 runt pulse recorded", 32'(flg), 32'h10);
    chk("R6 class3 after runt", r[3], 4*P);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0;
    src   = '0;
    clr   = 1'b0;
    t_por();
    t_lower();
    t_retrig();
    t_clear();
    t_src0();
    t_pulse();
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule